// File: doc/BRIEF.md
# I2C Address-Phase Status Tracker

This block follows an I2C bus from the point of view of a combined master/slave controller. It keeps three status flags for the first byte after each start condition. The extension flag shows that the address byte began with a reserved upper nibble. The match flag shows that the byte carried the controller's own 7-bit address. The direction flag shows whether the controller is in transmit status. From the direction flag the block also derives the enable for the controller's SDA output driver.

SCL and SDA enter through a multi-stage synchronizer. The block finds start and stop conditions and SCL edges, and counts the clocks of each byte. It captures only the first byte after a start. Flags change on the eighth rising SCL edge of that byte. They also change on the system-clock strobes for release, wait cancel and shift-register write, on the enable level, and on an arbitration-loss level input. The master side supplies a pulse when it generates a start, and it supplies the direction bit it puts on the bus.

Top module: `i2c_addr_status`

## Requirements
- R1: A start is SDA falling while SCL is high; a stop is SDA rising while SCL is high, both seen after the synchronizer, so a flag reacts on the third clock edge after a line change. A start clears the extension and match flags. A stop clears all three flags.
- R2: The extension flag sets on the eighth rising SCL edge of the first byte after a start when bits 7..4 of that byte (first bit on the wire is bit 7) are 0000 or 1111.
- R3: The match flag sets on the same edge when bits 7..1 of the first byte equal `local_addr`.
- R4: Bytes after the first one never set the extension or match flag, and the bit counter restarts at every start condition.
- R5: In slave mode (`master_mode`=0), the direction flag sets when bit 0 of the first byte is 1 and the block is addressed (extension or match flag set). It clears when that bit is 0, and on a detected start.
- R6: In master mode, a `start_gen` pulse sets the direction flag. On the eighth rising edge of the first byte, `master_dir_bit`=0 sets the flag and `master_dir_bit`=1 clears it.
- R7: The direction flag clears on a 0-to-1 change of `arb_lost`. It also clears whenever slave mode is active with both the extension and match flags at 0.
- R8: Reset, `enable`=0 and a `release_stb` pulse clear all three flags on the next edge; a low `enable` holds them at 0.
- R9: `sda_oe` is 1 only while the direction flag is 1 and after the falling SCL edge that ends the ninth clock of the first byte. `sda_out` equals `shift_out_bit` while `sda_oe` is 1 and is 1 otherwise.
- R10: During the ninth clock of any byte (from its ninth rising edge to the next rising edge), `wait_cancel_stb` clears the direction flag and `sda_oe`, while `shift_wr_stb` leaves the flag unchanged. Either strobe there gives a one-cycle `wait_release` pulse on the next edge.
- R11: When a set and a clear condition for a flag fall in the same cycle, the flag ends up 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Unit enable; low holds flags cleared |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| local_addr | input | 7 | Own slave address |
| master_mode | input | 1 | 1 while the controller acts as master |
| start_gen | input | 1 | Pulse: master generated a start |
| master_dir_bit | input | 1 | Direction bit the master puts in its first byte |
| arb_lost | input | 1 | Arbitration-loss level |
| release_stb | input | 1 | Pulse: leave communication |
| wait_cancel_stb | input | 1 | Pulse: cancel the clock-stretch wait |
| shift_wr_stb | input | 1 | Pulse: shift register written |
| shift_out_bit | input | 1 | Current shift-register output bit |
| ext_code_flag | output | 1 | Extension code received |
| addr_match_flag | output | 1 | Own address received |
| tx_status_flag | output | 1 | 1 = transmit status |
| sda_oe | output | 1 | SDA driver enable |
| sda_out | output | 1 | SDA driven value |
| wait_release | output | 1 | Pulse: wait released in the ninth clock |

## Verification
The assertions assume that the strobes are single-cycle pulses. They also assume that SCL and SDA change no faster than the synchronizer can follow, so that every line level lasts several clocks and SDA changes only while SCL is low, except for the starts and stops. The bench holds every bus phase for at least three clocks and raises SDA transitions only with SCL low. It pulses each strobe for exactly one cycle and times it either to land on the eighth-edge update cycle or inside the ninth-clock window. A reference model runs in the bench every clock, and fixed expectations taken from the requirements are checked at the end of each scenario.

// File: rtl/i2c_astat_pkg.sv
// Shared constants and types for the I2C address-phase status tracker.
// Assumes standard 8-bit I2C bytes followed by one acknowledge clock.
package i2c_astat_pkg;
    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned ADDR_W  = BYTE_W - 1;
    localparam int unsigned ACK_POS = BYTE_W + 1;
    localparam int unsigned CNT_W   = $clog2(ACK_POS + 1);

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } line_evt_t;
endpackage

// File: rtl/i2c_line_watch.sv
// Synchronizes SCL/SDA through SYNC_STAGES flops and decodes start, stop
// and SCL edges. Assumes line levels last longer than SYNC_STAGES+1 clocks.
module i2c_line_watch
    import i2c_astat_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      scl_in,
    input  logic      sda_in,
    output line_evt_t evt,
    output logic      sda_now
);
    localparam int unsigned LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] scl_pipe;
    logic [SYNC_STAGES-1:0] sda_pipe;
    logic                   scl_prev;
    logic                   sda_prev;
    logic                   scl_now;

    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
            // One synchronizer stage per line; idle bus level is high.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_pipe[g] <= 1'b1;
                    sda_pipe[g] <= 1'b1;
                end else if (g == 0) begin
                    scl_pipe[g] <= scl_in;
                    sda_pipe[g] <= sda_in;
                end else begin
                    scl_pipe[g] <= scl_pipe[(g == 0) ? 0 : g - 1];
                    sda_pipe[g] <= sda_pipe[(g == 0) ? 0 : g - 1];
                end
            end
        end
    endgenerate

    // Hold the previous synchronized level for edge decoding.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_now;
            sda_prev <= sda_now;
        end
    end

    assign scl_now = scl_pipe[LAST];
    assign sda_now = sda_pipe[LAST];

    // Decode bus conditions from the current and previous levels.
    always_comb begin
        evt.start = scl_now & scl_prev & sda_prev & ~sda_now;
        evt.stop  = scl_now & scl_prev & ~sda_prev & sda_now;
        evt.rise  = scl_now & ~scl_prev;
        evt.fall  = ~scl_now & scl_prev;
    end
endmodule

// File: rtl/i2c_bit_tracker.sv
// Counts SCL clocks 1..9 per byte after a start, captures the first byte
// and marks the ninth-clock window. Assumes events from i2c_line_watch.
module i2c_bit_tracker
    import i2c_astat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  line_evt_t         evt,
    input  logic              sda_now,
    output logic              byte_done,
    output logic [BYTE_W-1:0] byte_val,
    output logic              ninth_win,
    output logic              ninth_fall_first
);
    localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] ACK_CNT   = CNT_W'(ACK_POS);

    logic [CNT_W-1:0]  bit_cnt;
    logic              active;
    logic              first_byte;
    logic [BYTE_W-1:0] shreg;

    // Track transfer activity, the clock count and the first-byte window.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            bit_cnt    <= '0;
            active     <= 1'b0;
            first_byte <= 1'b0;
            shreg      <= '0;
        end else if (evt.start) begin
            bit_cnt    <= '0;
            active     <= 1'b1;
            first_byte <= 1'b1;
            shreg      <= '0;
        end else if (evt.stop) begin
            bit_cnt    <= '0;
            active     <= 1'b0;
            first_byte <= 1'b0;
        end else begin
            if (evt.rise && active) begin
                shreg   <= {shreg[BYTE_W-2:0], sda_now};
                bit_cnt <= (bit_cnt == ACK_CNT) ? CNT_W'(1) : bit_cnt + CNT_W'(1);
            end
            if (ninth_fall_first) begin
                first_byte <= 1'b0;
            end
        end
    end

    assign byte_done        = evt.rise & first_byte & (bit_cnt == LAST_DATA);
    assign byte_val         = {shreg[BYTE_W-2:0], sda_now};
    assign ninth_win        = active & (bit_cnt == ACK_CNT);
    assign ninth_fall_first = evt.fall & first_byte & (bit_cnt == ACK_CNT);

    // Counter never leaves its 0..9 range.
    p_cnt_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= ACK_CNT);
    // A start always rewinds the count for the next address byte.
    p_start_rewind_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (evt.start && enable) |=> (bit_cnt == '0 && first_byte));
endmodule

// File: rtl/i2c_flag_logic.sv
// Holds the extension, match and direction flags plus the SDA drive arm.
// Assumes strobes are one-cycle pulses; any clear condition beats a set.
module i2c_flag_logic
    import i2c_astat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  line_evt_t         evt,
    input  logic              byte_done,
    input  logic [BYTE_W-1:0] byte_val,
    input  logic              ninth_win,
    input  logic              ninth_fall_first,
    input  logic [ADDR_W-1:0] local_addr,
    input  logic              master_mode,
    input  logic              start_gen,
    input  logic              master_dir_bit,
    input  logic              arb_lost,
    input  logic              release_stb,
    input  logic              wait_cancel_stb,
    input  logic              shift_wr_stb,
    output logic              ext_flag,
    output logic              match_flag,
    output logic              trc_flag,
    output logic              drive_en,
    output logic              wait_rel
);
    logic [3:0] nibble;
    logic       ext_hit, match_hit;
    logic       ext_nx, match_nx, trc_nx, arm_nx;
    logic       clr_em, clr_trc, set_trc, unused_slave;
    logic       arb_prev, armed;

    assign nibble    = byte_val[BYTE_W-1 -: 4];
    assign ext_hit   = (nibble == 4'h0) || (nibble == 4'hF);
    assign match_hit = (byte_val[BYTE_W-1:1] == local_addr);

    // Next state of the extension and match flags.
    always_comb begin
        clr_em   = ~enable | evt.start | evt.stop | release_stb;
        ext_nx   = clr_em ? 1'b0 : (ext_flag | (byte_done & ext_hit));
        match_nx = clr_em ? 1'b0 : (match_flag | (byte_done & match_hit));
    end

    // Next state of the direction flag, clears taking priority.
    always_comb begin
        unused_slave = ~master_mode & ~ext_nx & ~match_nx;
        clr_trc = ~enable | evt.stop | release_stb
                | (arb_lost & ~arb_prev)
                | unused_slave
                | (wait_cancel_stb & ninth_win & trc_flag)
                | (~master_mode & evt.start)
                | (master_mode & byte_done & master_dir_bit);
        set_trc = master_mode ? (start_gen | (byte_done & ~master_dir_bit))
                              : (byte_done & byte_val[0]);
        trc_nx  = clr_trc ? 1'b0 : (set_trc | trc_flag);
    end

    // Arm SDA drive after the first byte's ninth clock while transmitting.
    always_comb begin
        if (~enable | evt.start | evt.stop | ~trc_nx) begin
            arm_nx = 1'b0;
        end else begin
            arm_nx = armed | ninth_fall_first;
        end
    end

    // Register flags, drive arm, loss edge history and wait-release pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_flag   <= 1'b0;
            match_flag <= 1'b0;
            trc_flag   <= 1'b0;
            armed      <= 1'b0;
            arb_prev   <= 1'b0;
            wait_rel   <= 1'b0;
        end else begin
            ext_flag   <= ext_nx;
            match_flag <= match_nx;
            trc_flag   <= trc_nx;
            armed      <= arm_nx;
            arb_prev   <= arb_lost;
            wait_rel   <= enable & ninth_win & (wait_cancel_stb | shift_wr_stb);
        end
    end

    assign drive_en = trc_flag & armed;

    // Extension flag can only rise from a completed first byte.
    p_ext_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ext_flag) |-> $past(byte_done));
    // Stop clears every flag.
    p_stop_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        evt.stop |=> (!ext_flag && !match_flag && !trc_flag));
    // Release clears every flag.
    p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        release_stb |=> (!ext_flag && !match_flag && !trc_flag));
    // Low enable leaves all flags cleared.
    p_enable_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!ext_flag && !match_flag && !trc_flag));
    // Arbitration loss edge returns to receive status.
    p_arb_loss_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arb_lost) |=> !trc_flag);
    // SDA drive only starts at the first byte's ninth falling edge.
    p_drive_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drive_en) |-> $past(ninth_fall_first));
    // Wait cancel in the ninth clock drops transmit status.
    p_wait_cancel_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_cancel_stb && ninth_win) |=> (!trc_flag && !drive_en));
endmodule

// File: rtl/i2c_addr_status.sv
// Top of the I2C address-phase status tracker: line watcher, bit tracker
// and flag logic. Assumes raw bus lines and system-clock control pulses.
module i2c_addr_status
    import i2c_astat_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic [ADDR_W-1:0] local_addr,
    input  logic              master_mode,
    input  logic              start_gen,
    input  logic              master_dir_bit,
    input  logic              arb_lost,
    input  logic              release_stb,
    input  logic              wait_cancel_stb,
    input  logic              shift_wr_stb,
    input  logic              shift_out_bit,
    output logic              ext_code_flag,
    output logic              addr_match_flag,
    output logic              tx_status_flag,
    output logic              sda_oe,
    output logic              sda_out,
    output logic              wait_release
);
    line_evt_t         evt;
    logic              sda_now;
    logic              byte_done;
    logic [BYTE_W-1:0] byte_val;
    logic              ninth_win;
    logic              ninth_fall_first;

    i2c_line_watch #(.SYNC_STAGES(SYNC_STAGES)) u_watch (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_in  (scl_in),
        .sda_in  (sda_in),
        .evt     (evt),
        .sda_now (sda_now)
    );

    i2c_bit_tracker u_track (
        .clk              (clk),
        .rst_n            (rst_n),
        .enable           (enable),
        .evt              (evt),
        .sda_now          (sda_now),
        .byte_done        (byte_done),
        .byte_val         (byte_val),
        .ninth_win        (ninth_win),
        .ninth_fall_first (ninth_fall_first)
    );

    i2c_flag_logic u_flags (
        .clk              (clk),
        .rst_n            (rst_n),
        .enable           (enable),
        .evt              (evt),
        .byte_done        (byte_done),
        .byte_val         (byte_val),
        .ninth_win        (ninth_win),
        .ninth_fall_first (ninth_fall_first),
        .local_addr       (local_addr),
        .master_mode      (master_mode),
        .start_gen        (start_gen),
        .master_dir_bit   (master_dir_bit),
        .arb_lost         (arb_lost),
        .release_stb      (release_stb),
        .wait_cancel_stb  (wait_cancel_stb),
        .shift_wr_stb     (shift_wr_stb),
        .ext_flag         (ext_code_flag),
        .match_flag       (addr_match_flag),
        .trc_flag         (tx_status_flag),
        .drive_en         (sda_oe),
        .wait_rel         (wait_release)
    );

    // Present the shift-register bit only while driving; else release high.
    assign sda_out = sda_oe ? shift_out_bit : 1'b1;

    // Driven SDA value follows the shift-register bit.
    p_sda_value_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe |-> (sda_out == shift_out_bit));
endmodule

// File: tb/i2c_addr_status_test.sv
module i2c_addr_status_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b1, scl = 1'b1, sda = 1'b1;
    logic [6:0] laddr = 7'h3A;
    logic mmode = 1'b0, sgen = 1'b0, mdir = 1'b0, arb = 1'b0;
    logic rel = 1'b0, wcan = 1'b0, swr = 1'b0, sbit = 1'b0;
    logic ext_o, mat_o, trc_o, oe_o, sout_o, wrel_o;

    int checks = 0, fails = 0, cyc = 0;
    bit done = 0, started = 0;

    always #5 clk = ~clk;

    i2c_addr_status uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .scl_in(scl), .sda_in(sda),
        .local_addr(laddr), .master_mode(mmode), .start_gen(sgen),
        .master_dir_bit(mdir), .arb_lost(arb), .release_stb(rel),
        .wait_cancel_stb(wcan), .shift_wr_stb(swr), .shift_out_bit(sbit),
        .ext_code_flag(ext_o), .addr_match_flag(mat_o), .tx_status_flag(trc_o),
        .sda_oe(oe_o), .sda_out(sout_o), .wait_release(wrel_o)
    );

    // Behavioural reference model state
    bit c1 = 1, c2 = 1, c3 = 1, d1 = 1, d2 = 1, d3 = 1;
    int cnt = 0;
    bit act = 0, first = 0;
    bit [7:0] sh = 0;
    bit m_ext = 0, m_mat = 0, m_trc = 0, m_arm = 0, m_alp = 0, m_wr = 0;

    always @(posedge clk) begin : ref_model
        bit st, sp, ri, fa, bd, nw, nf, e_n, m_n, t_n, clr, set;
        bit [7:0] bv;
        started = 1;
        if (!rst_n) begin
            c1 = 1; c2 = 1; c3 = 1; d1 = 1; d2 = 1; d3 = 1;
            cnt = 0; act = 0; first = 0; sh = 0;
            m_ext = 0; m_mat = 0; m_trc = 0; m_arm = 0; m_alp = 0; m_wr = 0;
        end else begin
            st = c2 && c3 && d3 && !d2;
            sp = c2 && c3 && !d3 && d2;
            ri = c2 && !c3;
            fa = !c2 && c3;
            bv = {sh[6:0], d2};
            bd = ri && first && cnt == 7;
            nw = act && cnt == 9;
            nf = fa && first && cnt == 9;
            if (!enable || st || sp || rel) begin
                e_n = 0; m_n = 0;
            end else begin
                e_n = m_ext || (bd && (bv[7:4] == 4'h0 || bv[7:4] == 4'hF));
                m_n = m_mat || (bd && bv[7:1] == laddr);
            end
            clr = !enable || sp || rel || (arb && !m_alp) || (!mmode && !e_n && !m_n)
                || (wcan && nw && m_trc) || (!mmode && st) || (mmode && bd && mdir);
            set = mmode ? (sgen || (bd && !mdir)) : (bd && bv[0]);
            t_n = clr ? 0 : (set ? 1 : m_trc);
            if (!enable || st || sp || !t_n) m_arm = 0;
            else if (nf) m_arm = 1;
            m_wr = enable && nw && (wcan || swr);
            m_ext = e_n; m_mat = m_n; m_trc = t_n; m_alp = arb;
            if (!enable) begin
                cnt = 0; act = 0; first = 0; sh = 0;
            end else if (st) begin
                cnt = 0; act = 1; first = 1; sh = 0;
            end else if (sp) begin
                cnt = 0; act = 0; first = 0;
            end else begin
                if (nf) first = 0;
                if (ri && act) begin
                    sh = bv;
                    cnt = (cnt == 9) ? 1 : cnt + 1;
                end
            end
            c3 = c2; c2 = c1; c1 = scl;
            d3 = d2; d2 = d1; d1 = sda;
        end
    end

    task automatic chk(input logic got, input logic exp, input string tag);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b at %0t", tag, got, exp, $time);
        end
    endtask

    // Compare the design against the model every cycle, away from the edge.
    always @(negedge clk) begin
        if (started && !done) begin
            chk(ext_o, m_ext, "R2 ext flag vs model");
            chk(mat_o, m_mat, "R3 match flag vs model");
            chk(trc_o, m_trc, "R5 direction flag vs model");
            chk(oe_o, m_trc && m_arm, "R9 sda_oe vs model");
            chk(sout_o, (m_trc && m_arm) ? sbit : 1'b1, "R9 sda_out vs model");
            chk(wrel_o, m_wr, "R10 wait_release vs model");
        end
    end

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL R1 watchdog: actual %0d cycles expected fewer than 150000", cyc);
            report();
            $finish;
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    // sel: 0 none, 1 release, 2 wait cancel, 3 shift write
    task automatic set_stb(input int sel, input logic v);
        if (sel == 1) rel = v;
        if (sel == 2) wcan = v;
        if (sel == 3) swr = v;
    endtask

    task automatic send_bit(input logic b, input int sel, input int at);
        sda = b;
        repeat (3) tick();
        scl = 1;
        for (int i = 0; i < 6; i++) begin
            if (i == at) set_stb(sel, 1);
            tick();
            set_stb(sel, 0);
        end
        scl = 0;
        repeat (5) tick();
    endtask

    task automatic send_byte(input logic [7:0] v, input int sel8, input int sel9);
        for (int i = 7; i >= 1; i--) send_bit(v[i], 0, -1);
        send_bit(v[0], sel8, 2);
        send_bit(1'b0, sel9, 4);
    endtask

    task automatic bus_start();
        sda = 1; repeat (3) tick();
        scl = 1; repeat (4) tick();
        sda = 0; repeat (5) tick();
        scl = 0; repeat (3) tick();
    endtask

    task automatic bus_stop();
        sda = 0; repeat (3) tick();
        scl = 1; repeat (4) tick();
        sda = 1; repeat (5) tick();
    endtask

    task automatic pulse_sgen();
        sgen = 1; tick(); sgen = 0; tick();
    endtask

    initial begin
        repeat (4) tick();
        chk(ext_o, 0, "R8 reset ext");
        chk(mat_o, 0, "R8 reset match");
        chk(trc_o, 0, "R8 reset direction");
        chk(oe_o, 0, "R9 reset sda_oe");
        rst_n = 1;
        repeat (4) tick();

        // Slave read, own address
        bus_start();
        send_byte(8'h75, 0, 0);
        chk(mat_o, 1, "R3 own address read");
        chk(ext_o, 0, "R2 nibble 0111 not extension");
        chk(trc_o, 1, "R5 slave transmit on LSB 1");
        chk(oe_o, 1, "R9 drive after ninth fall");
        sbit = 0; tick(); chk(sout_o, 0, "R9 sda_out follows bit 0");
        sbit = 1; tick(); chk(sout_o, 1, "R9 sda_out follows bit 1");
        send_byte(8'h00, 0, 3);
        chk(trc_o, 1, "R10 shift write keeps transmit");
        chk(ext_o, 0, "R4 later byte not evaluated");
        send_byte(8'h00, 0, 2);
        chk(trc_o, 0, "R10 wait cancel to receive");
        chk(oe_o, 0, "R10 wait cancel releases SDA");
        bus_stop();
        chk(mat_o, 0, "R1 stop clears match");

        // Slave write, own address, then release
        bus_start();
        send_byte(8'h74, 0, 0);
        chk(mat_o, 1, "R3 own address write");
        chk(trc_o, 0, "R5 LSB 0 keeps receive");
        chk(oe_o, 0, "R9 no drive in receive");
        rel = 1; tick(); rel = 0; tick();
        chk(mat_o, 0, "R8 release clears match");
        bus_stop();

        // Foreign address, then own address as second byte
        bus_start();
        send_byte(8'h41, 0, 0);
        chk(mat_o, 0, "R3 mismatch");
        chk(trc_o, 0, "R7 unaddressed slave stays receive");
        send_byte(8'h75, 0, 0);
        chk(mat_o, 0, "R4 second byte ignored");
        bus_stop();

        // Extension codes with repeated start
        bus_start();
        send_byte(8'h05, 0, 0);
        chk(ext_o, 1, "R2 nibble 0000");
        chk(trc_o, 1, "R5 extension read");
        bus_start();
        chk(ext_o, 0, "R1 start clears extension");
        chk(trc_o, 0, "R5 start clears direction");
        send_byte(8'hF2, 0, 0);
        chk(ext_o, 1, "R2 nibble 1111");
        chk(trc_o, 0, "R5 extension write");
        bus_stop();

        // Release on the eighth-edge cycle: clear wins
        bus_start();
        send_byte(8'h75, 1, 0);
        chk(mat_o, 0, "R11 release beats match set");
        chk(trc_o, 0, "R11 release beats direction set");
        bus_stop();

        // Master mode
        mmode = 1;
        pulse_sgen();
        chk(trc_o, 1, "R6 start generation sets transmit");
        bus_start();
        mdir = 0;
        send_byte(8'hA0, 0, 0);
        chk(trc_o, 1, "R6 master write stays transmit");
        chk(oe_o, 1, "R9 master drive after ninth fall");
        bus_start();
        pulse_sgen();
        mdir = 1;
        send_byte(8'hA1, 0, 0);
        chk(trc_o, 0, "R6 master read to receive");
        pulse_sgen();
        chk(trc_o, 1, "R6 start generation again");
        arb = 1; tick(); tick();
        chk(trc_o, 0, "R7 arbitration loss clears");
        arb = 0;
        bus_stop();
        mmode = 0; mdir = 0;

        // Enable drop
        bus_start();
        send_byte(8'h75, 0, 0);
        chk(mat_o, 1, "R3 matched before disable");
        enable = 0; tick(); tick();
        chk(mat_o, 0, "R8 disable clears match");
        chk(trc_o, 0, "R8 disable clears direction");
        chk(oe_o, 0, "R8 disable releases SDA");
        enable = 1;
        bus_stop();
        repeat (5) tick();

        done = 1;
        report();
        $finish;
    end
endmodule